// File: doc/BRIEF.md
# Prescaled 8-bit Timer with Dual Compare

This block is an 8-bit timer/counter for a microcontroller-style subsystem. A free-running prescaler divides the system clock according to a 3-bit clock-select code, and each prescaler terminal count advances the counter by one. Two compare registers are checked against every new count value. The counter rolls over on its own in three of the four waveform modes. In the clear-on-match mode it restarts from zero when it reaches compare register A.

Three events set sticky flag bits: rollover, a match with A and a match with B. A flag together with its mask bit and the global interrupt-enable input raises an interrupt request, and the block reports a vector index for the highest-priority pending source. The interrupt controller pulses an acknowledge to clear the flag it serviced. Software reaches all registers through a byte-wide bus with a combinational read path.

Top module: `tmr8_cmp`

## Requirements
- R1: While clock-select is 0 the counter holds its value however many clocks pass, and the prescaler is held at zero.
- R2: In the standard table (ALT_TABLE=0), clock-select 1, 2, 3, 4 and 5 divide by 1, 8, 64, 256 and 1024, and codes 6 and 7 keep the counter stopped. Starting from a stopped prescaler, clock-select 1 gives one step per clock and clock-select 3 gives the first step on the 64th clock.
- R3: With ALT_TABLE=1, codes 1 to 7 divide by 1, 8, 32, 64, 128, 256 and 1024. With code 6 the count reads 1 after 511 clocks and 2 after 512 clocks, counted from the write that selects it.
- R4: A step from 0xFF to 0x00 sets flag bit 0 (overflow) in modes 0 (normal), 1 (phase-correct PWM) and 3 (fast PWM). In this block all three modes count up and wrap.
- R5: A step to a value equal to compare A sets flag bit 1. A step to a value equal to compare B sets flag bit 2. The comparison uses the incremented value.
- R6: In mode 2 (CTC), a step whose incremented value equals compare A stores 0 in the counter and still sets flag bit 1.
- R7: irq_req is high only when some flag bit, its mask bit (mask bit 0 overflow, bit 1 compare A, bit 2 compare B) and gie are all 1. Otherwise the flags stay set and no request is raised.
- R8: An irq_ack pulse while irq_req is high clears the flag bit that belongs to the vector on irq_vec.
- R9: The vectors are 0 for compare A, 1 for compare B and 2 for overflow. When several sources are pending, the lowest vector number is presented.
- R10: Writing the flag register clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R11: If a hardware event sets a flag bit in the same cycle that an acknowledge or a bus write clears it, the bit ends up set.
- R12: The register map is: address 0 control (bits 2:0 clock-select, bits 5:4 mode), 1 count, 2 compare A, 3 compare B, 4 flags (bits 2:0), 5 mask (bits 2:0). Reads return the stored fields with zeros elsewhere, and everything reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 3 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Combinational read data for bus_addr |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Acknowledge of the presented vector |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 2 | Vector index of the highest-priority pending source |

## Verification
A compare-A match can set flag bit 1 on the same clock edge at which the interrupt controller acknowledges that same flag. The bench provokes this by first leaving the flag set from an earlier match. It then loads the counter one step below compare A, enables clock-select 1 for exactly one clock, and raises irq_ack on that clock. The collision is judged correct only if, afterwards, the flag still reads 1 and irq_req stays high, and a second plain acknowledge then clears it. Separately, random start values placed close to the compare values and to 0xFF are run through all four modes and compared against a step model, so matches, rollovers and clear-on-match restarts also land together in single steps.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

  typedef enum logic [1:0] {
    WAVE_NORMAL = 2'd0,
    WAVE_PHASE  = 2'd1,
    WAVE_CTC    = 2'd2,
    WAVE_FAST   = 2'd3
  } wave_e;

  localparam int NSRC  = 3;
  localparam int VEC_W = 2;
  localparam int DIV_W = 10;
  localparam int CS_W  = 3;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_COUNT = 3'd1;
  localparam logic [2:0] A_CMPA  = 3'd2;
  localparam logic [2:0] A_CMPB  = 3'd3;
  localparam logic [2:0] A_FLAGS = 3'd4;
  localparam logic [2:0] A_MASK  = 3'd5;

  // bit order equals the flag register layout
  typedef struct packed {
    logic cmpb;
    logic cmpa;
    logic ovf;
  } evt_t;

  // terminal-count mask (ratio - 1) for a clock-select code
  function automatic logic [DIV_W-1:0] div_mask(input logic [CS_W-1:0] cs, input bit alt);
    logic [DIV_W-1:0] m;
    m = '0;
    if (!alt) begin
      case (cs)
        3'd2:    m = DIV_W'(7);
        3'd3:    m = DIV_W'(63);
        3'd4:    m = DIV_W'(255);
        3'd5:    m = DIV_W'(1023);
        default: m = '0;
      endcase
    end else begin
      case (cs)
        3'd2:    m = DIV_W'(7);
        3'd3:    m = DIV_W'(31);
        3'd4:    m = DIV_W'(63);
        3'd5:    m = DIV_W'(127);
        3'd6:    m = DIV_W'(255);
        3'd7:    m = DIV_W'(1023);
        default: m = '0;
      endcase
    end
    return m;
  endfunction

  // whether a clock-select code runs the counter at all
  function automatic logic div_run(input logic [CS_W-1:0] cs, input bit alt);
    if (cs == '0) return 1'b0;
    if (!alt && cs > 3'd5) return 1'b0;
    return 1'b1;
  endfunction

  // flag bit index served by a vector number
  function automatic int vec_flag(input int v);
    case (v)
      0:       return 1;
      1:       return 2;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/tmr8_presc.sv
module tmr8_presc
  import tmr8_pkg::*;
#(
  parameter bit ALT_TABLE = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CS_W-1:0] cs,
  output logic            tick
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_d;
  logic [DIV_W-1:0] term;
  logic             run;

  always_comb begin
    term = div_mask(cs, ALT_TABLE);
    run  = div_run(cs, ALT_TABLE);
    div_d = run ? (div_q + DIV_W'(1)) : '0;
    tick = run && ((div_q & term) == term);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

endmodule

// File: rtl/tmr8_count.sv
module tmr8_count
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  wave_e            mode,
  input  logic [CNT_W-1:0] cmpa,
  input  logic [CNT_W-1:0] cmpb,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt,
  output evt_t             evt
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] inc;
  logic             cnt_en;

  always_comb begin
    inc    = cnt_q + CNT_W'(1);
    evt    = '0;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (wr_en) begin
      cnt_d  = wr_data;
      cnt_en = 1'b1;
    end else if (tick) begin
      cnt_en   = 1'b1;
      evt.ovf  = (cnt_q == '1);
      evt.cmpa = (inc == cmpa);
      evt.cmpb = (inc == cmpb);
      cnt_d    = ((mode == WAVE_CTC) && evt.cmpa) ? '0 : inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/tmr8_irq.sv
module tmr8_irq
  import tmr8_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  set,
  input  logic [NSRC-1:0]  w1c,
  input  logic [NSRC-1:0]  mask,
  input  logic             gie,
  input  logic             ack,
  output logic [NSRC-1:0]  flags,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec
);

  logic [NSRC-1:0] flags_q;
  logic [NSRC-1:0] flags_d;
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] ack_clr;

  always_comb begin
    pend    = flags_q & mask & {NSRC{gie}};
    irq_req = |pend;
    irq_vec = '0;
    for (int v = NSRC - 1; v >= 0; v--) begin
      if (pend[vec_flag(v)]) irq_vec = VEC_W'(v);
    end
    ack_clr = '0;
    if (ack && irq_req) ack_clr[vec_flag(int'(irq_vec))] = 1'b1;
    flags_d = (flags_q & ~w1c & ~ack_clr) | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags = flags_q;

endmodule

// File: rtl/tmr8_cmp.sv
module tmr8_cmp
  import tmr8_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter bit ALT_TABLE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             gie,
  input  logic             irq_ack,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec
);

  // reset: asserted at once, released after two clock edges
  logic rs0_q, rs1_q, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs0_q <= 1'b0;
      rs1_q <= 1'b0;
    end else begin
      rs0_q <= 1'b1;
      rs1_q <= rs0_q;
    end
  end
  assign rst_q = rs1_q;

  logic            wr_ctrl, cnt_wr, wr_cmpa, wr_cmpb, wr_flags, wr_mask;
  logic [CS_W-1:0] cs_q, cs_d;
  wave_e           mode_q, mode_d;
  logic [CNT_W-1:0] cmpa_q, cmpa_d, cmpb_q, cmpb_d;
  logic [NSRC-1:0] mask_q, mask_d;
  logic [NSRC-1:0] w1c;
  logic            tick;
  logic [CNT_W-1:0] cnt;
  evt_t            evt;
  logic [NSRC-1:0] flags;
  logic            unused_wbits;

  assign unused_wbits = ^{bus_wdata[CNT_W-1:6], bus_wdata[3]};

  always_comb begin
    wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    cnt_wr   = bus_wr && (bus_addr == A_COUNT);
    wr_cmpa  = bus_wr && (bus_addr == A_CMPA);
    wr_cmpb  = bus_wr && (bus_addr == A_CMPB);
    wr_flags = bus_wr && (bus_addr == A_FLAGS);
    wr_mask  = bus_wr && (bus_addr == A_MASK);
    cs_d     = bus_wdata[CS_W-1:0];
    mode_d   = wave_e'(bus_wdata[5:4]);
    cmpa_d   = bus_wdata;
    cmpb_d   = bus_wdata;
    mask_d   = bus_wdata[NSRC-1:0];
    w1c      = wr_flags ? bus_wdata[NSRC-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cs_q   <= '0;
      mode_q <= WAVE_NORMAL;
      cmpa_q <= '0;
      cmpb_q <= '0;
      mask_q <= '0;
    end else begin
      if (wr_ctrl) begin
        cs_q   <= cs_d;
        mode_q <= mode_d;
      end
      if (wr_cmpa) cmpa_q <= cmpa_d;
      if (wr_cmpb) cmpb_q <= cmpb_d;
      if (wr_mask) mask_q <= mask_d;
    end
  end

  tmr8_presc #(.ALT_TABLE(ALT_TABLE)) u_presc (
    .clk  (clk),
    .rst_n(rst_q),
    .cs   (cs_q),
    .tick (tick)
  );

  tmr8_count #(.CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .rst_n  (rst_q),
    .tick   (tick),
    .mode   (mode_q),
    .cmpa   (cmpa_q),
    .cmpb   (cmpb_q),
    .wr_en  (cnt_wr),
    .wr_data(bus_wdata),
    .cnt    (cnt),
    .evt    (evt)
  );

  tmr8_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_q),
    .set    (evt),
    .w1c    (w1c),
    .mask   (mask_q),
    .gie    (gie),
    .ack    (irq_ack),
    .flags  (flags),
    .irq_req(irq_req),
    .irq_vec(irq_vec)
  );

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = CNT_W'({mode_q, 1'b0, cs_q});
      A_COUNT: bus_rdata = cnt;
      A_CMPA:  bus_rdata = cmpa_q;
      A_CMPB:  bus_rdata = cmpb_q;
      A_FLAGS: bus_rdata = CNT_W'(flags);
      A_MASK:  bus_rdata = CNT_W'(mask_q);
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/tmr8_cmp_chk.sv
module tmr8_cmp_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       cs,
  input logic [1:0]       mode,
  input logic             tick,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmpa,
  input logic             evt_cmpa,
  input logic [2:0]       flags,
  input logic [2:0]       mask,
  input logic             gie,
  input logic             irq_ack,
  input logic             irq_req,
  input logic [1:0]       irq_vec
);

  logic [CNT_W-1:0] cnt_inc;
  assign cnt_inc = cnt + CNT_W'(1);

  AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (cs == 3'd0 && !cnt_wr) |=> $stable(cnt)); // R1

  AST_TICK_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (cs != 3'd0)); // R2

  AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && cnt == '1) |=> flags[0]); // R4

  AST_CMPA_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[1]) |-> $past(evt_cmpa)); // R5

  AST_CTC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && mode == 2'd2 && cnt_inc == cmpa) |=> (cnt == '0)); // R6

  AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (gie && ((flags & mask) != 3'd0))); // R7

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && irq_vec == 2'd0 && !evt_cmpa) |=> !flags[1]); // R8

  AST_VEC_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && flags[1] && mask[1]) |-> (irq_vec == 2'd0)); // R9

  AST_SET_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && evt_cmpa) |=> flags[1]); // R11

endmodule

bind tmr8_cmp tmr8_cmp_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_q),
  .cs      (cs_q),
  .mode    (mode_q),
  .tick    (tick),
  .cnt_wr  (cnt_wr),
  .cnt     (cnt),
  .cmpa    (cmpa_q),
  .evt_cmpa(evt.cmpa),
  .flags   (flags),
  .mask    (mask_q),
  .gie     (gie),
  .irq_ack (irq_ack),
  .irq_req (irq_req),
  .irq_vec (irq_vec)
);

// File: tb/test_tmr8_cmp.sv
`timescale 1ns/1ps
module test_tmr8_cmp;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic [2:0] addr, addr2;
  logic       wr, wr2;
  logic [7:0] wdata, wdata2;
  logic [7:0] rdata, rdata2;
  logic       gie, ack;
  logic       irq, irq2;
  logic [1:0] vec, vec2;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  tmr8_cmp #(.CNT_W(8), .ALT_TABLE(1'b0)) i_tmr8_cmp (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rdata(rdata), .gie(gie), .irq_ack(ack), .irq_req(irq), .irq_vec(vec)
  );

  tmr8_cmp #(.CNT_W(8), .ALT_TABLE(1'b1)) i_tmr8_cmp_alt (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr2), .bus_wr(wr2), .bus_wdata(wdata2),
    .bus_rdata(rdata2), .gie(1'b0), .irq_ack(1'b0), .irq_req(irq2), .irq_vec(vec2)
  );

  localparam logic [2:0] RC = 3'd0, RN = 3'd1, RA = 3'd2, RB = 3'd3, RF = 3'd4, RM = 3'd5;

  function automatic logic [7:0] ctrl(input int mode, input int cs);
    return {2'b00, 2'(mode), 1'b0, 3'(cs)};
  endfunction

  // step model built from R4, R5 and R6: returns {flags, count}
  function automatic logic [10:0] model_run(input int mode, input logic [7:0] c0,
                                            input logic [7:0] a, input logic [7:0] b, input int n);
    logic [7:0] c, nx;
    logic [2:0] f;
    c = c0;
    f = 3'd0;
    for (int i = 0; i < n; i++) begin
      nx = c + 8'd1;
      if (c == 8'hFF) f[0] = 1'b1;
      if (nx == a) f[1] = 1'b1;
      if (nx == b) f[2] = 1'b1;
      c = (mode == 2 && nx == a) ? 8'h00 : nx;
    end
    return {f, c};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic wr_alt(input logic [2:0] a, input logic [7:0] d);
    addr2 = a; wdata2 = d; wr2 = 1'b1;
    @(negedge clk);
    wr2 = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic rd_alt(input logic [2:0] a, output logic [7:0] v);
    addr2 = a;
    #1;
    v = rdata2;
  endtask

  task automatic prep(input int mode, input logic [7:0] c, input logic [7:0] a, input logic [7:0] b);
    wr_reg(RC, ctrl(mode, 0));
    wr_reg(RF, 8'h07);
    wr_reg(RA, a);
    wr_reg(RB, b);
    wr_reg(RN, c);
  endtask

  // exactly n prescaler steps with clock-select 1
  task automatic run_ticks(input int mode, input int n);
    wr_reg(RC, ctrl(mode, 1));
    repeat (n - 1) @(negedge clk);
    wr_reg(RC, ctrl(mode, 0));
  endtask

  task automatic ack_pulse();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL WDOG actual=timeout expected=finished");
      report();
    end
  end

  initial begin
    logic [7:0] v;
    logic [10:0] m;
    rst_n = 1'b0; wr = 1'b0; wr2 = 1'b0; addr = RC; addr2 = RC;
    wdata = 8'h00; wdata2 = 8'h00; gie = 1'b0; ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12 reset state and register map
    rd_reg(RN, v); check("R12 reset count", v, 0);
    rd_reg(RF, v); check("R12 reset flags", v, 0);
    check("R12 reset irq", irq, 0);
    wr_reg(RA, 8'hA5); rd_reg(RA, v); check("R12 cmpa readback", v, 8'hA5);
    wr_reg(RB, 8'h3C); rd_reg(RB, v); check("R12 cmpb readback", v, 8'h3C);
    wr_reg(RM, 8'hFD); rd_reg(RM, v); check("R12 mask readback", v, 8'h05);
    wr_reg(RC, 8'hE5); rd_reg(RC, v); check("R12 ctrl readback", v, 8'h25);
    wr_reg(RM, 8'h00);

    // R1 stopped counter
    prep(0, 8'h5A, 8'h5B, 8'h5B);
    repeat (1000) @(negedge clk);
    rd_reg(RN, v); check("R1 count frozen", v, 8'h5A);
    rd_reg(RF, v); check("R1 no flags", v, 0);

    // R2 divide by 1
    prep(0, 8'h00, 8'h80, 8'h80);
    run_ticks(0, 10);
    rd_reg(RN, v); check("R2 cs1 ten steps", v, 10);

    // R2 divide by 64
    prep(0, 8'h00, 8'hF0, 8'hF0);
    wr_reg(RC, ctrl(0, 3));
    repeat (63) @(negedge clk);
    rd_reg(RN, v); check("R2 cs3 after 63", v, 0);
    @(negedge clk);
    rd_reg(RN, v); check("R2 cs3 after 64", v, 1);
    wr_reg(RC, ctrl(0, 6));
    repeat (300) @(negedge clk);
    rd_reg(RN, v); check("R2 cs6 stopped", v, 1);
    wr_reg(RC, ctrl(0, 0));

    // R3 alternate table, divide by 256
    wr_alt(RC, ctrl(0, 6));
    repeat (255) @(negedge clk);
    rd_alt(RN, v); check("R3 after 255", v, 0);
    @(negedge clk);
    rd_alt(RN, v); check("R3 after 256", v, 1);
    repeat (255) @(negedge clk);
    rd_alt(RN, v); check("R3 after 511", v, 1);
    @(negedge clk);
    rd_alt(RN, v); check("R3 after 512", v, 2);
    wr_alt(RC, ctrl(0, 0));

    // R4 rollover in modes 0, 1, 3
    for (int md = 0; md < 4; md++) begin
      if (md == 2) continue;
      prep(md, 8'hFF, 8'h80, 8'h80);
      run_ticks(md, 1);
      rd_reg(RN, v); check($sformatf("R4 wrap count mode %0d", md), v, 0);
      rd_reg(RF, v); check($sformatf("R4 ovf flag mode %0d", md), v, 1);
    end

    // R5 compare flags
    prep(0, 8'h10, 8'h11, 8'h40);
    run_ticks(0, 1);
    rd_reg(RN, v); check("R5 count", v, 8'h11);
    rd_reg(RF, v); check("R5 cmpa flag", v, 2);
    prep(0, 8'h10, 8'h40, 8'h11);
    run_ticks(0, 1);
    rd_reg(RF, v); check("R5 cmpb flag", v, 4);

    // R10 write-one-to-clear
    wr_reg(RF, 8'h03); rd_reg(RF, v); check("R10 zero bits keep flag", v, 4);
    wr_reg(RF, 8'h00); rd_reg(RF, v); check("R10 zero write", v, 4);
    wr_reg(RF, 8'h04); rd_reg(RF, v); check("R10 one clears", v, 0);

    // R6 CTC restart
    prep(2, 8'h10, 8'h11, 8'h40);
    run_ticks(2, 1);
    rd_reg(RN, v); check("R6 ctc cleared", v, 0);
    rd_reg(RF, v); check("R6 ctc flag", v, 2);
    run_ticks(2, 3);
    rd_reg(RN, v); check("R6 ctc restarts", v, 3);

    // R7 request gating
    prep(0, 8'h10, 8'h11, 8'h40);
    run_ticks(0, 1);
    gie = 1'b1; #1; check("R7 mask clear", irq, 0);
    wr_reg(RM, 8'h02); gie = 1'b0; #1;
    check("R7 gie low", irq, 0);
    rd_reg(RF, v); check("R7 flag kept", v, 2);
    gie = 1'b1; #1;
    check("R7 request", irq, 1);
    check("R9 vec cmpa", vec, 0);
    wr_reg(RM, 8'h01); #1; check("R7 other mask", irq, 0);

    // R8 acknowledge
    wr_reg(RM, 8'h02); #1;
    ack_pulse();
    rd_reg(RF, v); check("R8 ack clears", v, 0);
    check("R8 req drops", irq, 0);

    // R9 priority with all three pending
    prep(0, 8'hFF, 8'h00, 8'h00);
    run_ticks(0, 1);
    rd_reg(RF, v); check("R9 all flags", v, 7);
    wr_reg(RM, 8'h07); #1;
    check("R9 first vec", vec, 0);
    ack_pulse(); #1;
    check("R9 second vec", vec, 1);
    rd_reg(RF, v); check("R9 flags after first ack", v, 5);
    ack_pulse(); #1;
    check("R9 third vec", vec, 2);
    ack_pulse(); #1;
    check("R9 all served", irq, 0);

    // R11 set in the same cycle as acknowledge
    wr_reg(RM, 8'h00);
    prep(0, 8'h20, 8'h21, 8'h80);
    run_ticks(0, 1);
    wr_reg(RN, 8'h20);
    wr_reg(RM, 8'h02); #1;
    check("R11 setup request", irq, 1);
    wr_reg(RC, ctrl(0, 1));
    ack = 1'b1;
    wr_reg(RC, ctrl(0, 0));
    ack = 1'b0;
    rd_reg(RF, v); check("R11 set wins", v, 2);
    check("R11 request stays", irq, 1);
    ack_pulse();
    rd_reg(RF, v); check("R11 later ack", v, 0);
    gie = 1'b0;
    wr_reg(RM, 8'h00);

    // random runs against the step model
    void'($urandom(32'd2718));
    for (int t = 0; t < 40; t++) begin
      int md, n;
      logic [7:0] c, a, b;
      md = int'($urandom % 4);
      c  = 8'($urandom);
      if ($urandom % 3 == 0) c = 8'hF8 + 8'($urandom % 8);
      a = c + 8'd1 + 8'($urandom % 8);
      b = c + 8'd1 + 8'($urandom % 12);
      if ($urandom % 4 == 0) a = 8'($urandom % 4);
      n = 1 + int'($urandom % 20);
      m = model_run(md, c, a, b, n);
      prep(md, c, a, b);
      run_ticks(md, n);
      rd_reg(RN, v); check($sformatf("R5 random count t%0d", t), v, m[7:0]);
      rd_reg(RF, v); check($sformatf("R6 random flags t%0d", t), v, {5'd0, m[10:8]});
    end

    done = 1'b1;
    report();
  end

endmodule